// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block sits beside a processor's local data bus and fires a debug trigger when a transferred operand equals a programmed pattern. Two 32-bit registers set it up: a pattern register holding the value to look for and a don't-care register where each set bit removes the matching pattern bit from the compare. Both are written and read through a small debug register port that selects a register by number.

On every data-phase strobe the block works out which byte lanes of the bus carry the operand from the two low address bits and the access size. Misaligned byte and word references are handled by the same lane mapping. The block right-aligns the operand and compares it, bit by bit, against the low-order bits of the pattern register. The don't-care register and the access width limit which bits take part. A match with the enable input set gives a one-cycle registered trigger pulse. The pattern and don't-care registers are not reset, so software must write them before it sets the enable.

Top module: `dbg_data_bkpt`

## Requirements
- R1: Register number 0x0E selects the 32-bit pattern register and 0x0F the 32-bit don't-care register. A write with `cfg_we` high stores `cfg_wdata` at the clock edge, and `cfg_rdata` returns the selected register's contents combinationally.
- R2: A write to any other register number changes neither register, and a read of any other number returns zero.
- R3: Byte access (`bus_size` = 2'b01): `bus_addr_lo` 0, 1, 2, 3 take the operand from bus bits [31:24], [23:16], [15:8], [7:0] in that order. It is compared with pattern bits [7:0].
- R4: Word access (`bus_size` = 2'b10): `bus_addr_lo[1]` = 0 takes bus bits [31:16] and 1 takes [15:0], whatever `bus_addr_lo[0]` is. The operand is compared with pattern bits [15:0].
- R5: Longword access (`bus_size` = 2'b00): all 32 bus bits are compared with the full pattern register, whatever the address bits are.
- R6: An operand bit takes part in the compare only when the don't-care bit at the same position (low-order aligned, as for the pattern) is 0. A don't-care bit of 1 makes that bit always match.
- R7: Size code 2'b11 never produces a trigger.
- R8: No trigger is produced unless `bus_valid` and `bkpt_en` are both high in the strobe cycle.
- R9: `trig` goes high for the one clock cycle after a qualifying matching strobe cycle and is low otherwise.
- R10: `trig` is low while `rst_n` is low and for the cycles after its release until a qualifying match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Debug register write strobe |
| cfg_addr | input | 5 | Debug register number |
| cfg_wdata | input | 32 | Debug register write data |
| cfg_rdata | output | 32 | Debug register read data for `cfg_addr` |
| bkpt_en | input | 1 | Trigger enable |
| bus_valid | input | 1 | Data-phase strobe of the watched bus |
| bus_addr_lo | input | 2 | Low address bits of the transfer |
| bus_size | input | 2 | Access size: 00 longword, 01 byte, 10 word, 11 reserved |
| bus_data | input | 32 | Data bus contents during the data phase |
| trig | output | 1 | Registered one-cycle breakpoint trigger |

## Verification
The assertions check on every cycle that the reserved size code, a missing strobe or a cleared enable never lets a trigger through. They also check that a longword operand that differs from the pattern in a cared-for bit is never reported, that writes land in the addressed register only, and that unknown register numbers read as zero. The byte and word lane choice for each address offset, the low-order alignment of pattern and don't-care bits, and the trigger firing on every true match can only be shown by the bench. It drives directed misaligned cases and random operands built to match or to miss in a single cared-for bit.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  localparam int unsigned DBP_REGNUM_W = 5;
  localparam logic [DBP_REGNUM_W-1:0] DBP_PATTERN_NUM = 5'h0E;
  localparam logic [DBP_REGNUM_W-1:0] DBP_DONTCARE_NUM = 5'h0F;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } dbp_size_e;

endpackage

// File: rtl/dbp_regfile.sv
module dbp_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_W = 5,
  parameter logic [NUM_W-1:0] PAT_NUM = 5'h0E,
  parameter logic [NUM_W-1:0] DC_NUM = 5'h0F
) (
  input  logic              clk,
  input  logic              we,
  input  logic [NUM_W-1:0]  num,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pat_q,
  output logic [DATA_W-1:0] dc_q
);

  logic              pat_en;
  logic              dc_en;
  logic [DATA_W-1:0] pat_d;
  logic [DATA_W-1:0] dc_d;

  always_comb begin
    pat_en = we && (num == PAT_NUM);
    dc_en  = we && (num == DC_NUM);
    pat_d  = wdata;
    dc_d   = wdata;
  end

  // no reset: contents are undefined until software writes them
  always_ff @(posedge clk) begin
    if (pat_en) pat_q <= pat_d;
  end

  always_ff @(posedge clk) begin
    if (dc_en) dc_q <= dc_d;
  end

  always_comb begin
    if (num == PAT_NUM)     rdata = pat_q;
    else if (num == DC_NUM) rdata = dc_q;
    else                    rdata = '0;
  end

endmodule

// File: rtl/dbp_lane_sel.sv
module dbp_lane_sel
  import dbp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           data,
  output logic [DATA_W-1:0]           operand,
  output logic [DATA_W-1:0]           width_mask,
  output logic                        size_ok
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] BYTE_M = {{(DATA_W-8){1'b0}}, {8{1'b1}}};
  localparam logic [DATA_W-1:0] WORD_M = {{(DATA_W-16){1'b0}}, {16{1'b1}}};

  logic [SH_W-1:0] shift;

  always_comb begin
    shift      = '0;
    width_mask = '0;
    size_ok    = 1'b1;
    unique case (dbp_size_e'(size))
      SZ_BYTE: begin
        // lane 0 is the most significant byte
        shift      = SH_W'(8 * (LANES - 1 - int'(addr_lo)));
        width_mask = BYTE_M;
      end
      SZ_WORD: begin
        shift      = SH_W'(16 * (LANES / 2 - 1 - int'(addr_lo >> 1)));
        width_mask = WORD_M;
      end
      SZ_LONG: begin
        shift      = '0;
        width_mask = '1;
      end
      default: begin
        size_ok = 1'b0;
      end
    endcase
    operand = data >> shift;
  end

endmodule

// File: rtl/dbp_match.sv
module dbp_match #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] dont_care,
  input  logic [DATA_W-1:0] width_mask,
  output logic              hit
);

  logic [DATA_W-1:0] diff;

  always_comb begin
    diff = (operand ^ pattern) & ~dont_care & width_mask;
    hit  = (diff == '0);
  end

endmodule

// File: rtl/dbg_data_bkpt.sv
module dbg_data_bkpt
  import dbp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [DBP_REGNUM_W-1:0]  cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic                     bkpt_en,
  input  logic                     bus_valid,
  input  logic [1:0]               bus_addr_lo,
  input  logic [1:0]               bus_size,
  input  logic [31:0]              bus_data,
  output logic                     trig
);

  localparam int unsigned ADDR_W = $clog2(DATA_W / 8);

  logic [RST_SYNC_STAGES-1:0] rst_pipe_q;
  logic                       rst_sync_n;
  logic [DATA_W-1:0]          val_q;
  logic [DATA_W-1:0]          msk_q;
  logic [DATA_W-1:0]          operand;
  logic [DATA_W-1:0]          width_mask;
  logic                       size_ok;
  logic                       hit;
  logic                       trig_d;
  logic                       trig_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_SYNC_STAGES-1];

  dbp_regfile #(
    .DATA_W (DATA_W),
    .NUM_W  (DBP_REGNUM_W),
    .PAT_NUM(DBP_PATTERN_NUM),
    .DC_NUM (DBP_DONTCARE_NUM)
  ) i_regs (
    .clk  (clk),
    .we   (cfg_we),
    .num  (cfg_addr),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .pat_q(val_q),
    .dc_q (msk_q)
  );

  dbp_lane_sel #(.DATA_W(DATA_W)) i_lanes (
    .addr_lo   (bus_addr_lo[ADDR_W-1:0]),
    .size      (bus_size),
    .data      (bus_data),
    .operand   (operand),
    .width_mask(width_mask),
    .size_ok   (size_ok)
  );

  dbp_match #(.DATA_W(DATA_W)) i_match (
    .operand   (operand),
    .pattern   (val_q),
    .dont_care (msk_q),
    .width_mask(width_mask),
    .hit       (hit)
  );

  always_comb begin
    trig_d = bkpt_en && bus_valid && size_ok && hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) trig_q <= 1'b0;
    else             trig_q <= trig_d;
  end

  assign trig = trig_q;

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker
  import dbp_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [DBP_REGNUM_W-1:0] cfg_addr,
  input logic [31:0]             cfg_wdata,
  input logic [31:0]             cfg_rdata,
  input logic                    bkpt_en,
  input logic                    bus_valid,
  input logic [1:0]              bus_size,
  input logic [31:0]             bus_data,
  input logic                    trig,
  input logic [31:0]             val_q,
  input logic [31:0]             msk_q
);

  logic known_num;
  assign known_num = (cfg_addr == DBP_PATTERN_NUM) || (cfg_addr == DBP_DONTCARE_NUM);

  // R1
  a_r1_pattern_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == DBP_PATTERN_NUM |=> val_q == $past(cfg_wdata));

  // R1
  a_r1_dontcare_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == DBP_DONTCARE_NUM |=> msk_q == $past(cfg_wdata));

  // R2
  a_r2_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !known_num |=> $stable(val_q) && $stable(msk_q));

  // R2
  a_r2_other_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !known_num |-> cfg_rdata == 32'h0);

  // R5 / R6
  a_r5_long_miss: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bkpt_en && bus_size == SZ_LONG && (((bus_data ^ val_q) & ~msk_q) != 32'h0)
    |=> !trig);

  // R7
  a_r7_rsvd_size: assert property (@(posedge clk) disable iff (!rst_n)
    bus_size == SZ_RSVD |=> !trig);

  // R8
  a_r8_needs_valid_en: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bkpt_en) |=> !trig);

endmodule

bind dbg_data_bkpt dbp_checker i_dbp_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .bkpt_en  (bkpt_en),
  .bus_valid(bus_valid),
  .bus_size (bus_size),
  .bus_data (bus_data),
  .trig     (trig),
  .val_q    (val_q),
  .msk_q    (msk_q)
);

// File: tb/test_dbg_data_bkpt.sv
module test_dbg_data_bkpt;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        bkpt_en;
  logic        bus_valid;
  logic [1:0]  bus_addr_lo;
  logic [1:0]  bus_size;
  logic [31:0] bus_data;
  logic        trig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_val;
  logic [31:0] m_msk;

  dbg_data_bkpt i_dbg_data_bkpt (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bkpt_en(bkpt_en),
    .bus_valid(bus_valid), .bus_addr_lo(bus_addr_lo), .bus_size(bus_size),
    .bus_data(bus_data), .trig(trig)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // operand extraction written as explicit slices from the requirements
  function automatic logic exp_trig(input logic en, input logic vld, input logic [1:0] a,
                                    input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] op;
    logic [31:0] wm;
    op = 32'h0;
    wm = 32'h0;
    case (sz)
      2'b01: begin
        wm = 32'h0000_00FF;
        case (a)
          2'd0: op = {24'h0, d[31:24]};
          2'd1: op = {24'h0, d[23:16]};
          2'd2: op = {24'h0, d[15:8]};
          default: op = {24'h0, d[7:0]};
        endcase
      end
      2'b10: begin
        wm = 32'h0000_FFFF;
        op = a[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]};
      end
      2'b00: begin
        wm = 32'hFFFF_FFFF;
        op = d;
      end
      default: return 1'b0;
    endcase
    for (int i = 0; i < 32; i++)
      if (wm[i] && !m_msk[i] && op[i] != m_val[i]) return 1'b0;
    return en && vld;
  endfunction

  task automatic wr(input logic [4:0] num, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = num; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (num == 5'h0E) m_val = d;
    if (num == 5'h0F) m_msk = d;
  endtask

  task automatic rd(input string req, input logic [4:0] num, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = num;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  // one strobe cycle followed by an idle cycle; check pulse, then its end
  task automatic bus(input string req, input logic en, input logic vld, input logic [1:0] a,
                     input logic [1:0] sz, input logic [31:0] d);
    logic e;
    e = exp_trig(en, vld, a, sz, d);
    @(negedge clk);
    bkpt_en = en; bus_valid = vld; bus_addr_lo = a; bus_size = sz; bus_data = d;
    @(negedge clk);
    check(req, {31'h0, trig}, {31'h0, e});
    bus_valid = 1'b0; bus_data = ~d;
    @(negedge clk);
    check("R9 pulse ends", {31'h0, trig}, 32'h0);
  endtask

  function automatic logic [31:0] place(input logic [1:0] a, input logic [1:0] sz,
                                        input logic [31:0] op, input logic [31:0] bg);
    logic [31:0] d;
    d = bg;
    case (sz)
      2'b01: d[8*(3-a) +: 8] = op[7:0];
      2'b10: d[16*(1-a[1]) +: 16] = op[15:0];
      default: d = op;
    endcase
    return d;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 5'h0; cfg_wdata = 32'h0;
    bkpt_en = 1'b0; bus_valid = 1'b0; bus_addr_lo = 2'b0; bus_size = 2'b0; bus_data = 32'h0;
    m_val = 32'h0; m_msk = 32'h0;
    repeat (3) @(negedge clk);
    check("R10 trig in reset", {31'h0, trig}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 trig after release", {31'h0, trig}, 32'h0);

    // R1 register access
    wr(5'h0E, 32'hA1B2_C3D4);
    wr(5'h0F, 32'h0000_0000);
    rd("R1 pattern readback", 5'h0E, 32'hA1B2_C3D4);
    rd("R1 dontcare readback", 5'h0F, 32'h0000_0000);
    // R2 unknown numbers
    wr(5'h0D, 32'hFFFF_FFFF);
    wr(5'h10, 32'h1234_5678);
    rd("R2 pattern untouched", 5'h0E, 32'hA1B2_C3D4);
    rd("R2 dontcare untouched", 5'h0F, 32'h0000_0000);
    rd("R2 read zero 0x0D", 5'h0D, 32'h0);
    rd("R2 read zero 0x1F", 5'h1F, 32'h0);

    // R5 longword, address ignored
    bus("R5 long match a=3", 1'b1, 1'b1, 2'd3, 2'b00, 32'hA1B2_C3D4);
    bus("R5 long miss", 1'b1, 1'b1, 2'd0, 2'b00, 32'hA1B2_C3D5);

    // R3 byte lanes: pattern low byte D4
    bus("R3 byte a=0", 1'b1, 1'b1, 2'd0, 2'b01, 32'hD400_0000);
    bus("R3 byte a=1", 1'b1, 1'b1, 2'd1, 2'b01, 32'h00D4_0000);
    bus("R3 byte a=2", 1'b1, 1'b1, 2'd2, 2'b01, 32'h0000_D400);
    bus("R3 byte a=3", 1'b1, 1'b1, 2'd3, 2'b01, 32'h0000_00D4);
    bus("R3 byte wrong lane", 1'b1, 1'b1, 2'd1, 2'b01, 32'hD400_00D4);

    // R4 word lanes: pattern low half C3D4, A[0] ignored
    bus("R4 word a=0", 1'b1, 1'b1, 2'd0, 2'b10, 32'hC3D4_0000);
    bus("R4 word a=1 misaligned", 1'b1, 1'b1, 2'd1, 2'b10, 32'hC3D4_1111);
    bus("R4 word a=2", 1'b1, 1'b1, 2'd2, 2'b10, 32'h0000_C3D4);
    bus("R4 word a=3 misaligned", 1'b1, 1'b1, 2'd3, 2'b10, 32'h2222_C3D4);
    bus("R4 word wrong half", 1'b1, 1'b1, 2'd2, 2'b10, 32'hC3D4_0000);

    // R6 don't-care bits, low-order aligned
    wr(5'h0F, 32'h0000_000F);
    bus("R6 masked nibble byte", 1'b1, 1'b1, 2'd0, 2'b01, 32'hD700_0000);
    bus("R6 unmasked bit differs", 1'b1, 1'b1, 2'd0, 2'b01, 32'hC400_0000);
    wr(5'h0F, 32'hFFFF_0000);
    bus("R6 upper masked long", 1'b1, 1'b1, 2'd0, 2'b00, 32'h0000_C3D4);

    // R7 reserved size, R8 enable and strobe
    wr(5'h0F, 32'hFFFF_FFFF);
    bus("R7 reserved size", 1'b1, 1'b1, 2'd0, 2'b11, 32'h0);
    bus("R8 enable low", 1'b0, 1'b1, 2'd0, 2'b00, 32'h0);
    bus("R8 strobe low", 1'b1, 1'b0, 2'd0, 2'b00, 32'h0);
    bus("R9 all dont-care fires", 1'b1, 1'b1, 2'd2, 2'b00, 32'h5555_AAAA);

    // R9 back-to-back matches give consecutive pulses
    @(negedge clk);
    bkpt_en = 1'b1; bus_valid = 1'b1; bus_size = 2'b00; bus_data = 32'h0;
    @(negedge clk);
    check("R9 first of pair", {31'h0, trig}, 32'h1);
    @(negedge clk);
    check("R9 second of pair", {31'h0, trig}, 32'h1);
    bus_valid = 1'b0;
    @(negedge clk);
    check("R9 idle after pair", {31'h0, trig}, 32'h0);

    // constrained random: R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 600; n++) begin
      logic [1:0] a, sz;
      logic [31:0] op, d;
      if (n % 50 == 0) begin
        wr(5'h0E, $urandom);
        wr(5'h0F, $urandom & $urandom & $urandom);
      end
      a  = 2'($urandom);
      sz = 2'($urandom);
      op = (m_val & ~m_msk) | ($urandom & m_msk);
      if ($urandom % 3 == 0) op = op ^ (32'h1 << ($urandom % 16));
      d  = place(a, sz, op, $urandom);
      bus("R3 R4 R5 R6 R7 R8 random", ($urandom % 8) != 0, ($urandom % 8) != 0, a, sz, d);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule